// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits between a local processor bus and a PCIe requester. It turns local addresses that land in a fixed outbound window into PCIe bus addresses. The window starts at a fixed local base. It is divided into a fixed number of equal regions, and the size of those regions is chosen at run time. Each region has its own translation target, so different regions can reach different address ranges on the same remote device.

Software programs two things through a simple register write port: the region size, and one target register per region. The target register holds the remote base address and an enable bit. For every request the block returns the following, one clock later:

- the translated PCIe address,
- a hit flag,
- the index of the region that matched.

Addresses that fall outside the window, or in a region that is not enabled, come back unchanged with the hit flag low. These are treated as local accesses.

Top module: `obwin_xlate`

## Requirements
- R1: The window begins at local address 0x6000_0000 and covers NUM_REGIONS regions. Any address below the base, or at or above base + NUM_REGIONS × region size, misses.
- R2: Register address 0 holds the size code in bits [1:0]. Code 0 gives 1 MB regions, 1 gives 2 MB, 2 gives 4 MB and 3 gives 8 MB.
- R3: Region n starts at base + n × region size. The reported region index is (address − base) divided by the region size.
- R4: On a hit, the output address is the region's target base plus the offset of the address within its region.
- R5: Register address 1+n is the target register of region n. Bits [31:20] hold the target base, in 1 MB units, and bit 0 enables the region. Every region translates through its own target.
- R6: A miss returns the request address unchanged, with the hit flag low and region index 0. A miss is an address outside the window, or one whose region is disabled.
- R7: After reset the region size is 1 MB, every region is disabled and the response valid flag is low.
- R8: The response appears on the clock edge that follows the request. The response valid flag follows the request valid flag with exactly one cycle of delay.
- R9: A register write in the same cycle as a request does not affect that request. It applies to every later request.
- R10: A write to a register address above NUM_REGIONS changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW (4) | Register address: 0 = size, 1+n = region n target |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request present |
| req_addr | input | LOC_AW (32) | Local bus address |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_addr | output | PCI_AW (32) | Translated or passed-through address |
| rsp_hit | output | 1 | Address translated through an enabled region |
| rsp_region | output | RIDX_W (3) | Index of the matched region, 0 on a miss |

## Verification
The bench builds the block with its defaults: eight regions, a 1 MB minimum region shift and 32-bit addresses on both sides. With these values every size code stays within the 32-bit address map. The largest window is 64 MB, ending at 0x6400_0000, so the bench can probe the first and last byte of every region and the address just past the window end for several size codes. Eight regions give three index bits, which lets the bench mix enabled and disabled regions and program distinct targets in the first and the last region.

// File: rtl/obw_pkg.sv
package obw_pkg;

  typedef enum logic [1:0] {
    SZ_1M = 2'd0,
    SZ_2M = 2'd1,
    SZ_4M = 2'd2,
    SZ_8M = 2'd3
  } size_e;

  localparam int NUM_SIZE_CODES = 4;

endpackage

// File: rtl/obw_cfg_regs.sv
module obw_cfg_regs #(
  parameter int NUM_REGIONS = 8,
  parameter int CFG_AW      = 4,
  parameter int DW          = 32,
  parameter int MIN_SHIFT   = 20,
  parameter int PCI_AW      = 32,
  localparam int TGT_W      = PCI_AW - MIN_SHIFT
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cfg_we,
  input  logic [CFG_AW-1:0]                 cfg_addr,
  input  logic [DW-1:0]                     cfg_wdata,
  output obw_pkg::size_e                    size_code,
  output logic [NUM_REGIONS-1:0][TGT_W-1:0] tgt_base,
  output logic [NUM_REGIONS-1:0]            tgt_en
);

  // Size register at address 0
  always_ff @(posedge clk) begin
    if (rst) begin
      size_code <= obw_pkg::SZ_1M;
    end else if (cfg_we && cfg_addr == '0) begin
      size_code <= obw_pkg::size_e'(cfg_wdata[1:0]);
    end
  end

  // One target register per region, at address 1+n
  for (genvar n = 0; n < NUM_REGIONS; n++) begin : g_region
    localparam logic [CFG_AW-1:0] MY_ADDR = CFG_AW'(n + 1);

    always_ff @(posedge clk) begin
      if (rst) begin
        tgt_base[n] <= '0;
        tgt_en[n]   <= 1'b0;
      end else if (cfg_we && cfg_addr == MY_ADDR) begin
        tgt_base[n] <= cfg_wdata[DW-1 -: TGT_W];
        tgt_en[n]   <= cfg_wdata[0];
      end
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata[DW-TGT_W-1:1];

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> ($stable(size_code) && $stable(tgt_en) && $stable(tgt_base))); // R5

  AST_HIGH_ADDR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr > CFG_AW'(NUM_REGIONS))
      |=> ($stable(size_code) && $stable(tgt_en) && $stable(tgt_base))); // R10

endmodule

// File: rtl/obw_decode.sv
module obw_decode #(
  parameter int                LOC_AW      = 32,
  parameter logic [LOC_AW-1:0] WIN_BASE    = 32'h6000_0000,
  parameter int                NUM_REGIONS = 8,
  parameter int                MIN_SHIFT   = 20,
  localparam int               RIDX_W      = $clog2(NUM_REGIONS)
) (
  input  logic [LOC_AW-1:0] addr,
  input  obw_pkg::size_e    size_code,
  output logic              win_hit,
  output logic [RIDX_W-1:0] ridx,
  output logic [LOC_AW-1:0] offset
);

  localparam int NC = obw_pkg::NUM_SIZE_CODES;

  logic [LOC_AW-1:0] rel;
  assign rel = addr - WIN_BASE;  // wraps to a large value below the base

  logic [NC-1:0]             cand_hit;
  logic [NC-1:0][RIDX_W-1:0] cand_idx;
  logic [NC-1:0][LOC_AW-1:0] cand_ofs;

  // One candidate decode per region size; the size code picks one
  for (genvar k = 0; k < NC; k++) begin : g_size
    localparam int                SH   = MIN_SHIFT + k;
    localparam logic [LOC_AW:0]   SPAN = (LOC_AW+1)'(NUM_REGIONS) << SH;
    localparam logic [LOC_AW-1:0] MASK = (LOC_AW'(1) << SH) - LOC_AW'(1);

    assign cand_hit[k] = {1'b0, rel} < SPAN;
    assign cand_idx[k] = RIDX_W'(rel >> SH);
    assign cand_ofs[k] = rel & MASK;
  end

  always_comb begin
    win_hit = cand_hit[size_code];
    ridx    = cand_idx[size_code];
    offset  = cand_ofs[size_code];
  end

  always_comb begin
    if (win_hit) begin
      AST_WIN_ABOVE_BASE: assert (addr >= WIN_BASE); // R1
    end
  end

endmodule

// File: rtl/obw_remap.sv
module obw_remap #(
  parameter int  NUM_REGIONS = 8,
  parameter int  LOC_AW      = 32,
  parameter int  PCI_AW      = 32,
  parameter int  MIN_SHIFT   = 20,
  localparam int TGT_W       = PCI_AW - MIN_SHIFT,
  localparam int RIDX_W      = $clog2(NUM_REGIONS)
) (
  input  logic [NUM_REGIONS-1:0][TGT_W-1:0] tgt_base,
  input  logic [NUM_REGIONS-1:0]            tgt_en,
  input  logic                              win_hit,
  input  logic [RIDX_W-1:0]                 ridx,
  input  logic [LOC_AW-1:0]                 offset,
  input  logic [LOC_AW-1:0]                 addr,
  output logic                              hit,
  output logic [RIDX_W-1:0]                 region,
  output logic [PCI_AW-1:0]                 paddr
);

  logic [PCI_AW-1:0] base_full;
  assign base_full = {tgt_base[ridx], {MIN_SHIFT{1'b0}}};

  always_comb begin
    hit = win_hit && tgt_en[ridx];
    if (hit) begin
      region = ridx;
      paddr  = base_full + PCI_AW'(offset);
    end else begin
      region = '0;
      paddr  = PCI_AW'(addr);
    end
  end

endmodule

// File: rtl/obwin_xlate.sv
module obwin_xlate #(
  parameter int                LOC_AW      = 32,
  parameter int                PCI_AW      = 32,
  parameter logic [LOC_AW-1:0] WIN_BASE    = 32'h6000_0000,
  parameter int                NUM_REGIONS = 8,
  parameter int                MIN_SHIFT   = 20,
  parameter int                CFG_AW      = 4,
  parameter int                DW          = 32,
  localparam int               RIDX_W      = $clog2(NUM_REGIONS),
  localparam int               TGT_W       = PCI_AW - MIN_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic              req_valid,
  input  logic [LOC_AW-1:0] req_addr,
  output logic              rsp_valid,
  output logic [PCI_AW-1:0] rsp_addr,
  output logic              rsp_hit,
  output logic [RIDX_W-1:0] rsp_region
);

  obw_pkg::size_e                    size_code;
  logic [NUM_REGIONS-1:0][TGT_W-1:0] tgt_base;
  logic [NUM_REGIONS-1:0]            tgt_en;
  logic                              win_hit;
  logic [RIDX_W-1:0]                 ridx;
  logic [LOC_AW-1:0]                 offset;
  logic                              nxt_hit;
  logic [RIDX_W-1:0]                 nxt_region;
  logic [PCI_AW-1:0]                 nxt_addr;

  obw_cfg_regs #(
    .NUM_REGIONS (NUM_REGIONS),
    .CFG_AW      (CFG_AW),
    .DW          (DW),
    .MIN_SHIFT   (MIN_SHIFT),
    .PCI_AW      (PCI_AW)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .size_code (size_code),
    .tgt_base  (tgt_base),
    .tgt_en    (tgt_en)
  );

  obw_decode #(
    .LOC_AW      (LOC_AW),
    .WIN_BASE    (WIN_BASE),
    .NUM_REGIONS (NUM_REGIONS),
    .MIN_SHIFT   (MIN_SHIFT)
  ) u_dec (
    .addr      (req_addr),
    .size_code (size_code),
    .win_hit   (win_hit),
    .ridx      (ridx),
    .offset    (offset)
  );

  obw_remap #(
    .NUM_REGIONS (NUM_REGIONS),
    .LOC_AW      (LOC_AW),
    .PCI_AW      (PCI_AW),
    .MIN_SHIFT   (MIN_SHIFT)
  ) u_map (
    .tgt_base (tgt_base),
    .tgt_en   (tgt_en),
    .win_hit  (win_hit),
    .ridx     (ridx),
    .offset   (offset),
    .addr     (req_addr),
    .hit      (nxt_hit),
    .region   (nxt_region),
    .paddr    (nxt_addr)
  );

  // Result register: a request sees the configuration present in its own cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_region <= '0;
      rsp_addr   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit    <= nxt_hit;
        rsp_region <= nxt_region;
        rsp_addr   <= nxt_addr;
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !rsp_valid); // R7

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R8

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R8

  AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !nxt_hit) |=> (!rsp_hit && rsp_addr == PCI_AW'($past(req_addr))
                                 && rsp_region == '0)); // R6

  AST_HIT_NOT_BELOW_BASE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && nxt_hit) |=> ($past(req_addr) >= WIN_BASE)); // R1

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> (rsp_addr[MIN_SHIFT-1:0] == $past(req_addr[MIN_SHIFT-1:0]))); // R4

endmodule

// File: tb/obwin_xlate_tb.sv
module obwin_xlate_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_addr;
  logic        rsp_hit;
  logic [2:0]  rsp_region;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  obwin_xlate u_dut (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_addr   (rsp_addr),
    .rsp_hit    (rsp_hit),
    .rsp_region (rsp_region)
  );

  // {addr, hit, region, expected address}; 1 MB regions
  // targets: r0=8000_0000, r1=9000_0000, r2 off, r3=A050_0000, r7=C000_0000
  localparam int NV = 10;
  localparam logic [67:0] VEC [NV] = '{
    {32'h6000_0480, 1'b1, 3'd0, 32'h8000_0480},  // R4 first region
    {32'h6010_0000, 1'b1, 3'd1, 32'h9000_0000},  // R3 region 1 start
    {32'h601F_FFFC, 1'b1, 3'd1, 32'h900F_FFFC},  // R3 region 1 end
    {32'h6020_0010, 1'b0, 3'd0, 32'h6020_0010},  // R6 disabled region
    {32'h6033_4440, 1'b1, 3'd3, 32'hA053_4440},  // R5 own target
    {32'h5FFF_FFFC, 1'b0, 3'd0, 32'h5FFF_FFFC},  // R1 below base
    {32'h6080_0000, 1'b0, 3'd0, 32'h6080_0000},  // R1 window end
    {32'h607F_FFF0, 1'b1, 3'd7, 32'hC00F_FFF0},  // R3 last region
    {32'h0000_0000, 1'b0, 3'd0, 32'h0000_0000},  // R6 low address
    {32'hFFFF_FFFC, 1'b0, 3'd0, 32'hFFFF_FFFC}   // R6 top address
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one request; outputs sampled at the next falling edge, after one register
  task automatic rq(input string tag, input logic [31:0] a,
                    input logic h, input logic [2:0] r, input logic [31:0] e);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " hit"}, 32'(rsp_hit), 32'(h));
    check({tag, " region"}, 32'(rsp_region), 32'(r));
    check({tag, " addr"}, rsp_addr, e);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R7 reset state
    check("R7 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R7 rsp_hit", 32'(rsp_hit), 32'd0);
    rq("R7 all disabled", 32'h6000_0000, 1'b0, 3'd0, 32'h6000_0000);
    rq("R7 1MB default", 32'h6010_0000, 1'b0, 3'd0, 32'h6010_0000);

    // R5 program targets
    wr(4'd1, 32'h8000_0001);
    wr(4'd2, 32'h9000_0001);
    wr(4'd3, 32'hDDD0_0000);   // region 2 written but disabled
    wr(4'd4, 32'hA050_0001);
    wr(4'd8, 32'hC000_0001);

    for (int i = 0; i < NV; i++) begin
      rq($sformatf("R1-table vec%0d", i), VEC[i][67:36], VEC[i][35], VEC[i][34:32], VEC[i][31:0]);
    end

    // R8 no request, no response
    @(negedge clk);
    check("R8 idle valid", 32'(rsp_valid), 32'd0);

    // R2 8 MB regions (code 3)
    wr(4'd0, 32'h0000_0003);
    rq("R2 8MB r0", 32'h6010_0000, 1'b1, 3'd0, 32'h8010_0000);
    rq("R3 8MB r1 start", 32'h6080_0000, 1'b1, 3'd1, 32'h9000_0000);
    rq("R3 8MB r7 end", 32'h63FF_FFF0, 1'b1, 3'd7, 32'hC07F_FFF0);
    rq("R1 8MB window end", 32'h6400_0000, 1'b0, 3'd0, 32'h6400_0000);

    // R2 2 MB regions (code 1)
    wr(4'd0, 32'h0000_0001);
    rq("R2 2MB r1", 32'h6030_0000, 1'b1, 3'd1, 32'h9010_0000);
    // R2 4 MB regions (code 2)
    wr(4'd0, 32'h0000_0002);
    rq("R2 4MB r3", 32'h60F0_0100, 1'b1, 3'd3, 32'hA080_0100);

    // R9 write in the same cycle as a request
    wr(4'd0, 32'h0000_0000);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h6010_0040;
    cfg_we = 1'b1; cfg_addr = 4'd2; cfg_wdata = 32'hB000_0001;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    check("R9 old target used", rsp_addr, 32'h9000_0040);
    rq("R9 new target next", 32'h6010_0040, 1'b1, 3'd1, 32'hB000_0040);

    // R10 writes above the last region register
    wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd15, 32'hFFFF_FFFF);
    rq("R10 r0 unchanged", 32'h6000_0000, 1'b1, 3'd0, 32'h8000_0000);
    rq("R10 size unchanged", 32'h6070_0008, 1'b1, 3'd7, 32'hC000_0008);

    // R6 disable a region
    wr(4'd1, 32'h8000_0000);
    rq("R6 disabled r0", 32'h6000_0100, 1'b0, 3'd0, 32'h6000_0100);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule